// File: doc/BRIEF.md
# Reset Cause and Software Reset Register

This block holds one 32-bit status word that records why the system last came out of reset. It also lets software ask for a new system reset. A cold hardware reset (`rst_n`) puts the block into its initial state. After that, the block sees every later system reset only as a one-cycle pulse on `rst_evt_i`. It keeps a small saturating count of those pulses. The count is how it tells the very first power-up from later resets: only when the count is still zero does a reset pulse load the word with the power-on cause alone.

Software reaches the word through a plain write strobe and a word-select bit. The word responds only when the select bit is high. The low word reads as zero and ignores writes.

The five cause bits do not all behave the same way on a write:
- The hardware-recorded causes are cleared by writing a one to them.
- The two software-request bits are set by writing a one to them.

Setting either software-request bit raises a one-cycle pulse on `sys_rst_req_o`. Setting the soft power-on bit also zeroes the count, so the reset that follows reports as a fresh power-on. A downstream reset controller acts on the request and later returns the event pulse.

Top module: `rsc_reg`

## Requirements
- R1: After `rst_n` is released, the upper word reads 0x00000000, `sys_rst_req_o` is low, and the internal reset count is zero.
- R2: With `addr_hi_i` low, `rdata_o` is 0. A write with `addr_hi_i` low changes no state and raises no request.
- R3: Bits 26:0 of the word always read 0. Ones written to them are dropped.
- R4: A write to the upper word clears each of bits 31 (power-on), 28 (button power-on) and 27 (button external reset) whose written bit is 1. Bits written as 0 are left unchanged.
- R5: A write to the upper word sets bit 30 (soft power-on) and/or bit 29 (soft external reset) wherever the written bit is 1. Writing 0 to these bits leaves them unchanged.
- R6: A write to the upper word with bit 30 or bit 29 equal to 1 drives `sys_rst_req_o` high for exactly the one cycle after the write cycle. `sys_rst_req_o` is low in every other cycle.
- R7: A write to the upper word with bit 30 equal to 1 zeroes the reset count. The next `rst_evt_i` pulse therefore loads the word with 0x80000000.
- R8: On an `rst_evt_i` cycle:
  - If the count is zero, the word becomes exactly 0x80000000.
  - Otherwise the word is unchanged.
  - In both cases the count increments.
- R9: The count saturates at 2^CNT_W-1 and never wraps back to zero. Any number of further events leaves the word unchanged.
- R10: When `rst_evt_i` and a write strobe occur in the same cycle, the event is applied and the write is discarded. No register update and no request come from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset, asynchronous assert |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| addr_hi_i | input | 1 | Word select: 1 selects the status word, 0 the empty lower word |
| wdata_i | input | 32 | Write data |
| rst_evt_i | input | 1 | One-cycle pulse marking a completed system reset |
| rdata_o | output | 32 | Read data for the selected word (combinational) |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume a correct write strobe, address and data on every cycle in which the strobe is high. They also assume `rst_evt_i` is a clean synchronous pulse, not a level held by the reset controller. Holding `rst_evt_i` high still gives well-defined saturating behaviour.

The stimulus drives all inputs half a cycle away from the sampling edge. It raises events only sparsely, with some collisions with writes on purpose. It also includes a directed run of events long enough to reach count saturation.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int unsigned WORD_W = 32;

    // Cause bit positions; software decodes these, so they are fixed.
    localparam int unsigned BIT_COLD_POR = 31;
    localparam int unsigned BIT_SW_POR   = 30;
    localparam int unsigned BIT_SW_XRST  = 29;
    localparam int unsigned BIT_BTN_POR  = 28;
    localparam int unsigned BIT_BTN_XRST = 27;

    localparam logic [WORD_W-1:0] LIVE_MASK  = 32'hF800_0000;
    localparam logic [WORD_W-1:0] W1C_MASK   = 32'h9800_0000;
    localparam logic [WORD_W-1:0] W1S_MASK   = 32'h6000_0000;
    localparam logic [WORD_W-1:0] FRESH_WORD = 32'h8000_0000;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_EVENT = 2'd1,
        ACT_WRITE = 2'd2
    } rsc_act_e;

endpackage

// File: rtl/rsc_wr_decode.sv
module rsc_wr_decode
    import rsc_pkg::*;
(
    input  logic              wr_en_i,
    input  logic              addr_hi_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              rst_evt_i,
    output rsc_act_e          act_o,
    output logic [WORD_W-1:0] clr_mask_o,
    output logic [WORD_W-1:0] set_mask_o,
    output logic              cnt_clr_o,
    output logic              req_trig_o
);

    logic [WORD_W-1:0] live_data;

    always_comb begin
        live_data  = wdata_i & LIVE_MASK;
        act_o      = ACT_IDLE;
        clr_mask_o = '0;
        set_mask_o = '0;
        cnt_clr_o  = 1'b0;
        req_trig_o = 1'b0;
        if (rst_evt_i) begin
            // The event always takes the cycle; a colliding write is dropped.
            act_o = ACT_EVENT;
        end else if (wr_en_i && addr_hi_i) begin
            act_o      = ACT_WRITE;
            clr_mask_o = live_data & W1C_MASK;
            set_mask_o = live_data & W1S_MASK;
            cnt_clr_o  = live_data[BIT_SW_POR];
            req_trig_o = live_data[BIT_SW_POR] | live_data[BIT_SW_XRST];
        end
    end

endmodule

// File: rtl/rsc_sat_cnt.sv
module rsc_sat_cnt #(
    parameter int unsigned CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt_q_i,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             is_zero_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_comb begin
        is_zero_o = (cnt_q_i == '0);
        cnt_d_o   = cnt_q_i;
        if (clr_i) begin
            cnt_d_o = '0;
        end else if (inc_i && (cnt_q_i != CNT_MAX)) begin
            cnt_d_o = cnt_q_i + 1'b1;
        end
    end

endmodule

// File: rtl/rsc_reg.sv
module rsc_reg
    import rsc_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic        addr_hi_i,
    input  logic [31:0] wdata_i,
    input  logic        rst_evt_i,
    output logic [31:0] rdata_o,
    output logic        sys_rst_req_o
);

    typedef struct packed {
        logic [WORD_W-1:0] stat;
        logic [CNT_W-1:0]  cnt;
        logic              req;
    } state_t;

    state_t state_d, state_q;

    rsc_act_e          act;
    logic [WORD_W-1:0] clr_mask;
    logic [WORD_W-1:0] set_mask;
    logic              cnt_clr;
    logic              req_trig;
    logic [CNT_W-1:0]  cnt_next;
    logic              cnt_zero;

    rsc_wr_decode u_dec (
        .wr_en_i    (wr_en_i),
        .addr_hi_i  (addr_hi_i),
        .wdata_i    (wdata_i),
        .rst_evt_i  (rst_evt_i),
        .act_o      (act),
        .clr_mask_o (clr_mask),
        .set_mask_o (set_mask),
        .cnt_clr_o  (cnt_clr),
        .req_trig_o (req_trig)
    );

    rsc_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .cnt_q_i   (state_q.cnt),
        .inc_i     (act == ACT_EVENT),
        .clr_i     (cnt_clr),
        .cnt_d_o   (cnt_next),
        .is_zero_o (cnt_zero)
    );

    always_comb begin
        state_d     = state_q;
        state_d.req = 1'b0;
        state_d.cnt = cnt_next;
        unique case (act)
            ACT_EVENT: begin
                if (cnt_zero) state_d.stat = FRESH_WORD;
            end
            ACT_WRITE: begin
                state_d.stat = ((state_q.stat & ~clr_mask) | set_mask) & LIVE_MASK;
                state_d.req  = req_trig;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o       = addr_hi_i ? state_q.stat : '0;
    assign sys_rst_req_o = state_q.req;

endmodule

// File: rtl/rsc_reg_chk.sv
module rsc_reg_chk #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic             addr_hi_i,
    input logic [31:0]      wdata_i,
    input logic             rst_evt_i,
    input logic             sys_rst_req_o,
    input logic [31:0]      stat_i,
    input logic [CNT_W-1:0] cnt_i
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic hi_wr;
    assign hi_wr = wr_en_i && addr_hi_i && !rst_evt_i;

    a_r6_req_after_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr && (wdata_i[30] || wdata_i[29]) |=> sys_rst_req_o);

    a_r6_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_wr && (wdata_i[30] || wdata_i[29])) |=> !sys_rst_req_o);

    a_r4_w1c_cold: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr && wdata_i[31] |=> !stat_i[31]);

    a_r5_w1s_soft_por: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr && wdata_i[30] |=> stat_i[30]);

    a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr && wdata_i[30] |=> cnt_i == '0);

    a_r8_fresh_load: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt_i && (cnt_i == '0) |=> stat_i == 32'h8000_0000);

    a_r8_keep_word: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt_i && (cnt_i != '0) |=> $stable(stat_i));

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt_i && (cnt_i == CNT_MAX) |=> cnt_i == CNT_MAX);

    a_r2_low_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !addr_hi_i && !rst_evt_i |=> $stable(stat_i) && $stable(cnt_i));

    a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_i[26:0] == '0);

endmodule

bind rsc_reg rsc_reg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en_i),
    .addr_hi_i     (addr_hi_i),
    .wdata_i       (wdata_i),
    .rst_evt_i     (rst_evt_i),
    .sys_rst_req_o (sys_rst_req_o),
    .stat_i        (state_q.stat),
    .cnt_i         (state_q.cnt)
);

// File: tb/rsc_reg_tb_top.sv
module rsc_reg_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned CNT_W      = 4;
    localparam int unsigned CNT_MAX    = (1 << CNT_W) - 1;
    localparam int unsigned WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        addr_hi_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic        rst_evt_i = 1'b0;
    logic [31:0] rdata_o;
    logic        sys_rst_req_o;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;

    logic [31:0] exp_word = '0;
    int unsigned exp_cnt  = 0;
    logic        exp_req  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsc_reg #(.CNT_W(CNT_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .addr_hi_i     (addr_hi_i),
        .wdata_i       (wdata_i),
        .rst_evt_i     (rst_evt_i),
        .rdata_o       (rdata_o),
        .sys_rst_req_o (sys_rst_req_o)
    );

    function automatic logic [31:0] next_word(logic [31:0] w, int unsigned c,
                                              logic wr, logic hi, logic [31:0] d, logic ev);
        logic [31:0] v;
        if (ev) return (c == 0) ? 32'h8000_0000 : w;
        if (wr && hi) begin
            v = d & 32'hF800_0000;
            return (w & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
        end
        return w;
    endfunction

    function automatic int unsigned next_cnt(int unsigned c, logic wr, logic hi,
                                             logic [31:0] d, logic ev);
        if (ev) return (c == CNT_MAX) ? c : c + 1;
        if (wr && hi && d[30]) return 0;
        return c;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle's inputs after the falling edge, check outputs, then apply the model at the rising edge.
    task automatic cyc(string tag, logic wr, logic hi, logic [31:0] d, logic ev);
        @(negedge clk);
        wr_en_i = wr; addr_hi_i = hi; wdata_i = d; rst_evt_i = ev;
        #1;
        check(tag, "rdata", rdata_o, hi ? exp_word : 32'h0);
        check(tag, "req", {31'b0, sys_rst_req_o}, {31'b0, exp_req});
        @(posedge clk);
        exp_req  = !ev && wr && hi && (d[30] || d[29]);
        exp_word = next_word(exp_word, exp_cnt, wr, hi, d, ev);
        exp_cnt  = next_cnt(exp_cnt, wr, hi, d, ev);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic wr, hi, ev;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle state after reset
        cyc("R1", 1'b0, 1'b1, 32'h0, 1'b0);
        // R8: first event with zero count loads the fresh word
        cyc("R8", 1'b0, 1'b1, 32'h0, 1'b1);
        cyc("R8", 1'b0, 1'b1, 32'h0, 1'b0);
        // R2: low word reads zero and ignores writes
        cyc("R2", 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
        cyc("R2", 1'b0, 1'b1, 32'h0, 1'b0);
        // R4: write-one-to-clear of the power-on bit
        cyc("R4", 1'b1, 1'b1, 32'h8000_0000, 1'b0);
        cyc("R4", 1'b0, 1'b1, 32'h0, 1'b0);
        // R8: nonzero count leaves the word
        cyc("R8", 1'b0, 1'b1, 32'h0, 1'b1);
        cyc("R8", 1'b0, 1'b1, 32'h0, 1'b0);
        // R5 and R6: set soft external bit, single pulse
        cyc("R5", 1'b1, 1'b1, 32'h2000_0000, 1'b0);
        cyc("R6", 1'b0, 1'b1, 32'h0, 1'b0);
        cyc("R6", 1'b0, 1'b1, 32'h0, 1'b0);
        // R3: low bits dropped
        cyc("R3", 1'b1, 1'b1, 32'h07FF_FFFF, 1'b0);
        cyc("R3", 1'b0, 1'b1, 32'h0, 1'b0);
        // R5: zeros leave set bits
        cyc("R5", 1'b1, 1'b1, 32'h0, 1'b0);
        // R7: soft power-on clears count, next event reloads
        cyc("R7", 1'b1, 1'b1, 32'h4000_0000, 1'b0);
        cyc("R7", 1'b0, 1'b1, 32'h0, 1'b1);
        cyc("R7", 1'b0, 1'b1, 32'h0, 1'b0);
        // R10: collision, event wins and write is dropped
        cyc("R10", 1'b1, 1'b1, 32'hC000_0000, 1'b1);
        cyc("R10", 1'b0, 1'b1, 32'h0, 1'b0);
        // R9: saturation never reloads the fresh word
        cyc("R9", 1'b1, 1'b1, 32'hF800_0000, 1'b0);
        for (int i = 0; i < 2 * CNT_MAX + 3; i++) cyc("R9", 1'b0, 1'b1, 32'h0, 1'b1);
        cyc("R9", 1'b0, 1'b1, 32'h0, 1'b0);

        // Random mix of reads, writes and sparse events
        for (int i = 0; i < 4000; i++) begin
            wr = ($urandom_range(0, 2) == 0);
            hi = ($urandom_range(0, 3) != 0);
            ev = ($urandom_range(0, 15) == 0);
            d  = $urandom();
            cyc("R4/R5/R6/R8 random", wr, hi, d, ev);
        end
        cyc("R6 tail", 1'b0, 1'b1, 32'h0, 1'b0);

        summary();
        $finish;
    end

endmodule